// File: doc/BRIEF.md
# Log-Domain Approximate Unsigned Multiplier

This block multiplies two wide unsigned operands without a multiplier array. Each operand is turned into an approximate base-2 logarithm. The integer part of that logarithm is the index of the operand's leading one. The fractional part is formed from the bits below that one, plus a piecewise-linear correction. The two logarithms are summed by a ripple carry-propagate adder. The sum is then converted back to the linear domain: a second piecewise-linear correction rebuilds a 1.f mantissa, and the mantissa is shifted left by the integer part of the sum.

The result is an approximate 64-bit product with a small, bounded relative error. It suits datapaths such as function-evaluation interpolators, where energy matters more than the last bits of precision. A zero on either input skips the converters and gives an exact zero.

The operand-to-product path is combinational. A single output register gives one cycle of latency, and a synchronous active-high reset clears that register. The fractional precision of both converters is fixed at 16 bits. The logarithm converter splits its fraction range into nine segments, with the lowest eighth cut in two. The antilogarithm converter uses eight equal segments.

Top module: `logmul_top`

## Requirements
- R1: While `rst` is high at a rising edge, `product` becomes 0 after that edge, whatever the operands are.
- R2: `product` shows the operands sampled at the previous rising edge. It holds steady between edges, even when the operands change mid-cycle.
- R3: If either operand is 0, the product is exactly 0, including when the other operand is all ones.
- R4: If both operands are powers of two, the product is exact and equals 2^(i+j), where i and j are the leading-one bit indices of the operands.
- R5: For any two non-zero operands, |product − a·b| ≤ floor(a·b / 50) + 1, where a·b is the exact product.
- R6: For non-zero operands with leading-one indices i and j, 2^(i+j) ≤ product < 2^(i+j+3).
- R7: Full-scale operands never wrap around. The product for 0xFFFFFFFF × 0xFFFFFFFF and for 2^31 × 2^31 meets R5, and a result that would exceed 64 bits is clamped to all ones.
- R8: The product does not depend on operand order: swapping `op_a` and `op_b` gives the same value.
- R9: R5 holds for operands whose fraction field (the 16 bits below the leading one) falls on the start of every logarithm segment: 1/16, and k/8 for k = 1 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the product register |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| product | output | 64 | Registered approximate unsigned product |

## Verification
Two pairs of functions can fall in the same cycle.

- **Reset and operand capture.** The bench raises reset while non-zero operands sit on the inputs. It then expects a zero product after the edge, not the product of those operands.
- **Zero bypass and full-scale clamp.** The bench pairs a zero with an all-ones or 0xDEADBEEF operand. The zero bypass must win over the clamp path, so the result must be exactly zero rather than a clamped or approximate value.

The remaining results are judged against the exact product computed in the bench, using the R5 error bound and the R6 bracket. Power-of-two pairs must match exactly.

// File: rtl/logmul_pkg.sv
package logmul_pkg;

  // Fixed-point precision of logarithm fractions; segment constants are Q16.
  localparam int LF = 16;
  localparam int LOG_SEGS  = 9;
  localparam int ANTI_SEGS = 8;
  localparam int SEG_IDX_W = $clog2(LOG_SEGS);
  localparam int SLOPE_W   = 9;   // signed slope, 1/256 units

  typedef logic signed [LF+1:0]      corr_t;
  typedef logic signed [SLOPE_W-1:0] slope_t;

  // Value of log2(1+f) - f at each log segment start (Q16).
  function automatic corr_t log_seg_base(input logic [SEG_IDX_W-1:0] s);
    case (s)
      4'd0:    return corr_t'(0);
      4'd1:    return corr_t'(1636);
      4'd2:    return corr_t'(2944);
      4'd3:    return corr_t'(4714);
      4'd4:    return corr_t'(5533);
      4'd5:    return corr_t'(5568);
      4'd6:    return corr_t'(4944);
      4'd7:    return corr_t'(3759);
      4'd8:    return corr_t'(2090);
      default: return corr_t'(0);
    endcase
  endfunction

  // Chord slope of the log correction in each segment (1/256 units).
  function automatic slope_t log_seg_slope(input logic [SEG_IDX_W-1:0] s);
    case (s)
      4'd0:    return slope_t'(102);
      4'd1:    return slope_t'(82);
      4'd2:    return slope_t'(55);
      4'd3:    return slope_t'(26);
      4'd4:    return slope_t'(1);
      4'd5:    return slope_t'(-20);
      4'd6:    return slope_t'(-37);
      4'd7:    return slope_t'(-52);
      4'd8:    return slope_t'(-65);
      default: return slope_t'(0);
    endcase
  endfunction

  // Value of 2^u - 1 - u at each antilog segment start (Q16).
  function automatic corr_t anti_seg_base(input logic [2:0] s);
    case (s)
      3'd0:    return corr_t'(0);
      3'd1:    return corr_t'(-2260);
      3'd2:    return corr_t'(-3984);
      3'd3:    return corr_t'(-5122);
      3'd4:    return corr_t'(-5622);
      3'd5:    return corr_t'(-5426);
      3'd6:    return corr_t'(-4470);
      default: return corr_t'(-2686);
    endcase
  endfunction

  function automatic slope_t anti_seg_slope(input logic [2:0] s);
    case (s)
      3'd0:    return slope_t'(-71);
      3'd1:    return slope_t'(-54);
      3'd2:    return slope_t'(-36);
      3'd3:    return slope_t'(-16);
      3'd4:    return slope_t'(6);
      3'd5:    return slope_t'(30);
      3'd6:    return slope_t'(56);
      default: return slope_t'(84);
    endcase
  endfunction

  // Offset times slope using only shifted adds, scaled back by 1/256.
  function automatic corr_t shift_add_scale(input logic [LF-1:0] d, input slope_t k);
    logic [SLOPE_W-2:0]    mag;
    logic [LF+SLOPE_W-2:0] acc;
    corr_t                 mag_term;
    mag = k[SLOPE_W-1] ? (SLOPE_W-1)'(-k) : k[SLOPE_W-2:0];
    acc = '0;
    for (int i = 0; i < SLOPE_W-1; i++) begin
      if (mag[i]) acc = acc + ((LF+SLOPE_W-1)'(d) << i);
    end
    mag_term = corr_t'({2'b00, acc[LF+SLOPE_W-2:SLOPE_W-1]});
    return k[SLOPE_W-1] ? -mag_term : mag_term;
  endfunction

endpackage

// File: rtl/logmul_lead_one.sv
module logmul_lead_one #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/logmul_cpa.sv
module logmul_cpa #(
  parameter int W = 22
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   s
);
  logic [W:0] cy;
  assign cy[0] = 1'b0;
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_fa
      assign s[g]    = x[g] ^ y[g] ^ cy[g];
      assign cy[g+1] = (x[g] & y[g]) | (cy[g] & (x[g] ^ y[g]));
    end
  endgenerate
  assign s[W] = cy[W];
endmodule

// File: rtl/logmul_log_conv.sv
module logmul_log_conv
  import logmul_pkg::*;
#(
  parameter int OP_W = 32,
  parameter int PW   = $clog2(OP_W),
  parameter int LW   = PW + 1 + LF
) (
  input  logic [OP_W-1:0] op,
  output logic [LW-1:0]   log_val,
  output logic            is_zero
);
  logic [PW-1:0]          lead;
  logic                   nonzero;
  logic [OP_W-1:0]        norm;
  logic [LF-1:0]          frac;
  logic [SEG_IDX_W-1:0]   seg;
  logic [LF-1:0]          seg_start;
  logic [LF-1:0]          offs;
  corr_t                  corr;
  logic signed [LF+2:0]   mant;

  logmul_lead_one #(.W(OP_W), .PW(PW)) lead_i (
    .vec (op),
    .pos (lead),
    .any (nonzero)
  );

  assign is_zero = ~nonzero;
  assign norm    = op << (PW'(OP_W-1) - lead);

  generate
    if (OP_W-1 > LF) begin : g_trunc
      logic unused_low;
      assign frac       = norm[OP_W-2 -: LF];
      assign unused_low = ^{norm[OP_W-1], norm[OP_W-2-LF:0]};
    end else if (OP_W-1 == LF) begin : g_exact
      logic unused_top;
      assign frac       = norm[OP_W-2:0];
      assign unused_top = norm[OP_W-1];
    end else begin : g_pad
      logic unused_top;
      assign frac       = {norm[OP_W-2:0], {(LF-OP_W+1){1'b0}}};
      assign unused_top = norm[OP_W-1];
    end
  endgenerate

  // Nine segments: lowest eighth is halved, the rest are eighths.
  always_comb begin
    if (frac[LF-1 -: 3] == 3'd0) begin
      seg       = frac[LF-4] ? SEG_IDX_W'(1) : SEG_IDX_W'(0);
      seg_start = frac[LF-4] ? (LF'(1) << (LF-4)) : '0;
    end else begin
      seg       = SEG_IDX_W'(frac[LF-1 -: 3]) + SEG_IDX_W'(1);
      seg_start = {frac[LF-1 -: 3], {(LF-3){1'b0}}};
    end
    offs = frac - seg_start;
    corr = log_seg_base(seg) + shift_add_scale(offs, log_seg_slope(seg));
    mant = $signed({3'b000, frac}) + $signed({corr[LF+1], corr});
  end

  assign log_val = LW'({lead, {LF{1'b0}}}) + LW'($unsigned(mant));
endmodule

// File: rtl/logmul_antilog_conv.sv
module logmul_antilog_conv
  import logmul_pkg::*;
#(
  parameter int OP_W = 32,
  parameter int SW   = 23
) (
  input  logic [SW-1:0]     sum_log,
  output logic [2*OP_W-1:0] lin
);
  localparam int PROD_W = 2 * OP_W;
  localparam int IW     = SW - LF;
  localparam int WW     = PROD_W + LF + 2;

  logic [IW-1:0]        ipart;
  logic [LF-1:0]        fpart;
  logic [2:0]           seg;
  logic [LF-1:0]        offs;
  corr_t                g;
  logic signed [LF+2:0] msum;
  logic [LF+1:0]        mant;
  logic [WW-1:0]        wide;
  logic                 clamp;
  logic                 unused_low;

  assign ipart = sum_log[SW-1:LF];
  assign fpart = sum_log[LF-1:0];

  always_comb begin
    seg  = fpart[LF-1 -: 3];
    offs = fpart - {seg, {(LF-3){1'b0}}};
    g    = anti_seg_base(seg) + shift_add_scale(offs, anti_seg_slope(seg));
    msum = $signed({3'b001, {LF{1'b0}}}) + $signed({3'b000, fpart})
         + $signed({g[LF+1], g});
    mant = msum[LF+1:0];
  end

  always_comb begin
    if (ipart >= IW'(PROD_W)) begin
      wide  = '0;
      clamp = 1'b1;
    end else begin
      wide  = WW'(mant) << ipart;
      clamp = |wide[WW-1:PROD_W+LF];
    end
    lin = clamp ? {PROD_W{1'b1}} : wide[PROD_W+LF-1:LF];
  end

  assign unused_low = ^wide[LF-1:0];
endmodule

// File: rtl/logmul_top.sv
module logmul_top
  import logmul_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] product
);
  localparam int PW     = $clog2(OP_W);
  localparam int LW     = PW + 1 + LF;
  localparam int SW     = LW + 1;
  localparam int PROD_W = 2 * OP_W;

  logic [LW-1:0]     log_a, log_b;
  logic              zero_a, zero_b;
  logic [SW-1:0]     log_sum;
  logic [PROD_W-1:0] lin;

  logmul_log_conv #(.OP_W(OP_W), .PW(PW), .LW(LW)) conv_a_i (
    .op (op_a), .log_val (log_a), .is_zero (zero_a)
  );

  logmul_log_conv #(.OP_W(OP_W), .PW(PW), .LW(LW)) conv_b_i (
    .op (op_b), .log_val (log_b), .is_zero (zero_b)
  );

  logmul_cpa #(.W(LW)) add_i (
    .x (log_a), .y (log_b), .s (log_sum)
  );

  logmul_antilog_conv #(.OP_W(OP_W), .SW(SW)) anti_i (
    .sum_log (log_sum), .lin (lin)
  );

  always_ff @(posedge clk) begin
    if (rst)                   product <= '0;
    else if (zero_a || zero_b) product <= '0;
    else                       product <= lin;
  end
endmodule

// File: rtl/logmul_chk.sv
module logmul_chk #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [2*OP_W-1:0] product
);
  localparam int PROD_W = 2 * OP_W;

  function automatic logic [7:0] top_bit(input logic [OP_W-1:0] v);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < OP_W; i++) if (v[i]) m = 8'(i);
    return m;
  endfunction

  logic [7:0]        msum;
  logic [PROD_W-1:0] wa, wb;
  assign msum = top_bit(op_a) + top_bit(op_b);
  assign wa   = PROD_W'(op_a);
  assign wb   = PROD_W'(op_b);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> product == '0);

  // R3
  zero_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 || op_b == '0) |=> product == '0);

  // R4
  pow2_exact_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(op_a) == 1 && $countones(op_b) == 1)
      |=> product == ($past(wa) * $past(wb)));

  // R6
  bracket_low_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a != '0 && op_b != '0) |=> product >= (PROD_W'(1) << $past(msum)));

  // R6
  bracket_high_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a != '0 && op_b != '0) |=> (product >> ($past(msum) + 8'd3)) == '0);
endmodule

bind logmul_top logmul_chk #(.OP_W(OP_W)) chk_i (
  .clk (clk), .rst (rst), .op_a (op_a), .op_b (op_b), .product (product)
);

// File: tb/logmul_top_tb_top.sv
`timescale 1ns/1ps
module logmul_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [63:0] product;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  logmul_top dut_i (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .product(product));

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] exact;
    logic        must_match;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'd3,          32'd3,          64'd9,                    1'b0},
    '{32'd1,          32'd1,          64'd1,                    1'b1},
    '{32'd1024,       32'd65536,      64'd67108864,             1'b1},
    '{32'h8000_0000,  32'h8000_0000,  64'h4000_0000_0000_0000,  1'b1},
    '{32'd1000,       32'd1000,       64'd1000000,              1'b0},
    '{32'd12345,      32'd678,        64'd8369910,              1'b0},
    '{32'hFFFF_FFFF,  32'hFFFF_FFFF,  64'hFFFF_FFFE_0000_0001,  1'b0},
    '{32'd7,          32'd9,          64'd63,                   1'b0},
    '{32'd0,          32'd123,        64'd0,                    1'b1},
    '{32'hDEAD_BEEF,  32'd0,          64'd0,                    1'b1},
    '{32'd100000,     32'd3,          64'd300000,               1'b0},
    '{32'd65535,      32'd65537,      64'hFFFF_FFFF,            1'b0}
  };

  function automatic int msb32(input logic [31:0] v);
    int m = 0;
    for (int i = 0; i < 32; i++) if (v[i]) m = i;
    return m;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, output logic [63:0] p);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    p = product;
  endtask

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_bound(input string req, input logic [31:0] a, input logic [31:0] b,
                             input logic [63:0] p);
    logic [63:0] exact, diff, lim;
    exact = {32'd0, a} * {32'd0, b};
    diff  = (p > exact) ? p - exact : exact - p;
    lim   = exact / 50 + 1;
    tests++;
    if (diff > lim) begin
      fails++;
      $display("FAIL %s: %0d x %0d actual %0d expected %0d (+/-%0d)", req, a, b, p, exact, lim);
    end
  endtask

  task automatic check_bracket(input string req, input logic [31:0] a, input logic [31:0] b,
                               input logic [63:0] p);
    int s;
    logic [63:0] lo;
    s  = msb32(a) + msb32(b);
    lo = 64'd1 << s;
    tests++;
    if (p < lo || (p >> (s + 3)) != 0) begin
      fails++;
      $display("FAIL %s: actual %0h expected range [2^%0d, 2^%0d)", req, p, s, s + 3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] p, q;
    logic [31:0] a, b;

    // R1: reset state with non-zero operands present
    op_a = 32'd77;
    op_b = 32'd99;
    repeat (3) @(negedge clk);
    check_eq("R1 reset", product, 64'd0);
    rst = 1'b0;

    // Vector table: R3 zero cases, R4 exact cases, R5 approximate cases
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, p);
      if (VECS[i].exact == 64'd0)  check_eq("R3 zero operand", p, 64'd0);
      else if (VECS[i].must_match) check_eq("R4 power of two", p, VECS[i].exact);
      else                         check_bound("R5 error bound", VECS[i].a, VECS[i].b, p);
    end

    // R2: latency and hold between edges
    apply(32'd2, 32'd4, p);
    check_eq("R2 first result", p, 64'd8);
    @(negedge clk);
    op_a = 32'd16;
    op_b = 32'd16;
    #1;
    check_eq("R2 hold mid-cycle", product, 64'd8);
    @(negedge clk);
    check_eq("R2 next result", product, 64'd256);

    // R3: zero paired with full-scale operand, both orders
    apply(32'hFFFF_FFFF, 32'd0, p);
    check_eq("R3 zero with max", p, 64'd0);
    apply(32'd0, 32'hFFFF_FFFF, p);
    check_eq("R3 max with zero", p, 64'd0);

    // R7: full-scale operands
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, p);
    check_bound("R7 max x max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, p);
    apply(32'h8000_0000, 32'h8000_0000, p);
    check_bound("R7 top bit squared", 32'h8000_0000, 32'h8000_0000, p);
    apply(32'hFFFF_FFFF, 32'h8000_0001, p);
    check_bound("R7 near full scale", 32'hFFFF_FFFF, 32'h8000_0001, p);

    // R9: operands at each log segment start
    a = 32'h0001_1000;
    apply(a, 32'd3, p);
    check_bound("R9 segment 1/16", a, 32'd3, p);
    for (int k = 1; k < 8; k++) begin
      a = 32'h0001_0000 | (32'(k) << 13);
      apply(a, 32'd3, p);
      check_bound("R9 segment k/8", a, 32'd3, p);
      apply(a, a, p);
      check_bound("R9 segment squared", a, a, p);
    end

    // R5 and R6 over random operands of varied magnitude
    for (int n = 0; n < 400; n++) begin
      a = $urandom() >> ($urandom() % 32);
      b = $urandom() >> ($urandom() % 32);
      if (a == 0) a = 32'd5;
      if (b == 0) b = 32'd11;
      apply(a, b, p);
      check_bound("R5 random", a, b, p);
      check_bracket("R6 random", a, b, p);
    end

    // R8: operand order has no effect
    for (int n = 0; n < 40; n++) begin
      a = $urandom() >> ($urandom() % 32);
      b = $urandom() >> ($urandom() % 32);
      apply(a, b, p);
      apply(b, a, q);
      check_eq("R8 commutative", q, p);
    end

    // R1: reset asserted mid-run wins over capture of non-zero operands
    apply(32'd5, 32'd7, p);
    @(negedge clk);
    rst  = 1'b1;
    op_a = 32'd1000;
    op_b = 32'd1000;
    @(negedge clk);
    check_eq("R1 reset mid-run", product, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check_bound("R1 release", 32'd1000, 32'd1000, product);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule